// File: doc/BRIEF.md
# Pulsed overload protection sequencer

This block decides when an output power stage may conduct. It watches three things: a digital overload indication from the current-limit circuit, a pair of thermal comparator outputs (one asserted above the upper junction threshold and one asserted below the lower threshold), and a software enable. From these it drives the power-stage enable and two fault flags, one for overload and one for overtemperature.

Two overload policies are available. In pulsed (dynamic) mode, an overload starts a retry cycle. The output is switched off for a long period, then switched back on for a short trial window one tenth as long. Only a trial window that passes with no overload returns the block to normal operation. In clamp (static) mode, the output never switches off for overload, and the overload flag follows the overload input.

The thermal flag has hysteresis. It sets on the hot comparator and clears only on the cool comparator. While it is set, it overrides the retry sequencer. Both period lengths count in clock cycles, so a testbench can scale them down.

Top module: `load_fault_sequencer`

## Requirements
- R1: After reset both fault flags are 0 and the sequencer is idle, so with the enable at 1 and no fault the output enable is 1.
- R2: While `pwr_en_i` is 0, `out_en_o` and `ovl_flag_o` are 0 in that same cycle. A clock edge with the enable at 0 returns the sequencer to idle.
- R3: In pulsed mode (`static_mode_i` = 0), if the overload input is 1 at a clock edge while the sequencer is idle, then from that edge `out_en_o` is 0 and `ovl_flag_o` is 1 for exactly `OFF_CYCLES` cycles. Overload during that off period has no effect.
- R4: After the off period, `out_en_o` is 1 for a trial window of `OFF_CYCLES/10` cycles, and `ovl_flag_o` stays 1 during that window.
- R5: An overload seen at any clock edge inside the trial window, including its last edge, starts a new full off period from that edge.
- R6: If a trial window completes with no overload, the sequencer returns to idle at the following edge. `ovl_flag_o` goes to 0 and `out_en_o` stays 1.
- R7: In clamp mode (`static_mode_i` = 1), `out_en_o` stays 1 whatever the overload input does. `ovl_flag_o` equals the overload input registered one cycle earlier.
- R8: If the mode changes from clamp to pulsed while the overload input is 1, the first edge in pulsed mode starts an off period.
- R9: If `temp_hot_i` is 1 at a clock edge, then from that edge `ot_flag_o` is 1 and `out_en_o` is 0. When both comparator inputs are 1 at once, the hot input wins.
- R10: Once set, `ot_flag_o` clears only at an edge where `temp_cool_i` is 1 and `temp_hot_i` is 0. At that edge the output is re-enabled.
- R11: The thermal fault overrides the retry sequence. While `ot_flag_o` is 1, `ovl_flag_o` is 0. After the thermal flag clears, the sequencer restarts from idle, so an overload that is still present starts a fresh full off period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pwr_en_i | input | 1 | Software enable of the power output |
| static_mode_i | input | 1 | 1 selects clamp overload handling, 0 selects pulsed retry |
| overload_i | input | 1 | Digital overload indication from the current limiter |
| temp_hot_i | input | 1 | Junction above the upper thermal threshold |
| temp_cool_i | input | 1 | Junction below the lower thermal threshold |
| out_en_o | output | 1 | Enable of the output power stage |
| ovl_flag_o | output | 1 | Overload fault flag |
| ot_flag_o | output | 1 | Overtemperature fault flag |

## Verification
A wrong count in the window counter shows at `out_en_o` as an off period or trial window that is one or more cycles too long or too short. It becomes visible at the first edge where the two differ, so the bench checks every cycle of each window, not only its end. A sequencer stuck outside idle, or a thermal latch that clears early, shows at the flags at the next edge after the event that should have moved it. Each stimulus is therefore followed by a port check in the very next cycle.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

  // Phases of the overload retry sequencer.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_OFF  = 2'd1,
    PH_ON   = 2'd2
  } lfs_phase_t;

  // Trial window length derived from the off period.
  function automatic int unsigned lfs_on_len(input int unsigned off_len);
    return off_len / 10;
  endfunction

endpackage

// File: rtl/lfs_reset_sync.sv
module lfs_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/lfs_thermal_latch.sv
module lfs_thermal_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic hot_i,
  input  logic cool_i,
  output logic ot_next_o,
  output logic ot_o
);

  logic ot_q;
  logic ot_d;
  logic ot_we;

  // Hot wins; otherwise the flag holds until cool is seen.
  always_comb begin
    ot_d = ot_q;
    if (hot_i) begin
      ot_d = 1'b1;
    end else if (cool_i) begin
      ot_d = 1'b0;
    end
  end

  assign ot_we = (ot_d != ot_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ot_q <= 1'b0;
    end else if (ot_we) begin
      ot_q <= ot_d;
    end
  end

  assign ot_next_o = ot_d;
  assign ot_o      = ot_q;

  a_r10_stays_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_q && !cool_i) |=> ot_q);

  a_r9_hot_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hot_i |=> ot_q);

endmodule

// File: rtl/lfs_hiccup_seq.sv
module lfs_hiccup_seq
  import lfs_pkg::*;
#(
  parameter int unsigned OFF_CYCLES = 45_000_000,
  parameter int unsigned ON_CYCLES  = 4_500_000,
  parameter int unsigned CNT_W      = 26
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold_i,
  input  logic       overload_i,
  output lfs_phase_t phase_o
);

  localparam logic [CNT_W-1:0] OFF_LAST = CNT_W'(OFF_CYCLES - 1);
  localparam logic [CNT_W-1:0] ON_LAST  = CNT_W'(ON_CYCLES - 1);

  lfs_phase_t       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_we;

  // Next-state logic.
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (hold_i) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (overload_i) begin
            phase_d = PH_OFF;
            cnt_d   = '0;
          end
        end
        PH_OFF: begin
          if (cnt_q == OFF_LAST) begin
            phase_d = PH_ON;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_ON: begin
          if (overload_i) begin
            phase_d = PH_OFF;
            cnt_d   = '0;
          end else if (cnt_q == ON_LAST) begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  assign cnt_we = (cnt_d != cnt_q);

  // Registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_we) begin
      cnt_q <= cnt_d;
    end
  end

  assign phase_o = phase_q;

  a_r3_idle_trips: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && !hold_i && overload_i) |=> (phase_q == PH_OFF));

  a_r3_off_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_OFF) |-> (cnt_q <= OFF_LAST));

  a_r4_on_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ON) |-> (cnt_q <= ON_LAST));

  a_r5_retry: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ON && !hold_i && overload_i) |=> (phase_q == PH_OFF));

  a_r2_hold_idles: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (phase_q == PH_IDLE));

endmodule

// File: rtl/load_fault_sequencer.sv
module load_fault_sequencer
  import lfs_pkg::*;
#(
  parameter int unsigned OFF_CYCLES = 45_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_en_i,
  input  logic static_mode_i,
  input  logic overload_i,
  input  logic temp_hot_i,
  input  logic temp_cool_i,
  output logic out_en_o,
  output logic ovl_flag_o,
  output logic ot_flag_o
);

  localparam int unsigned ON_CYCLES = lfs_on_len(OFF_CYCLES);
  localparam int unsigned CNT_W     = (OFF_CYCLES > 2) ? $clog2(OFF_CYCLES) : 1;

  logic       rst_n_sync;
  logic       ot_next;
  logic       ot_q;
  logic       seq_hold;
  lfs_phase_t phase;
  logic       clamp_flag_q;
  logic       clamp_flag_d;
  logic       clamp_we;

  lfs_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  lfs_thermal_latch u_therm (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .hot_i     (temp_hot_i),
    .cool_i    (temp_cool_i),
    .ot_next_o (ot_next),
    .ot_o      (ot_q)
  );

  // Sequencer runs only in pulsed mode, enabled, and with no thermal fault
  // either present or arriving at this edge.
  assign seq_hold = !pwr_en_i || static_mode_i || ot_next;

  lfs_hiccup_seq #(
    .OFF_CYCLES (OFF_CYCLES),
    .ON_CYCLES  (ON_CYCLES),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .hold_i     (seq_hold),
    .overload_i (overload_i),
    .phase_o    (phase)
  );

  // Clamp-mode flag tracks the overload input with one register of delay.
  assign clamp_flag_d = overload_i && pwr_en_i && !ot_next;
  assign clamp_we     = (clamp_flag_d != clamp_flag_q);

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      clamp_flag_q <= 1'b0;
    end else if (clamp_we) begin
      clamp_flag_q <= clamp_flag_d;
    end
  end

  assign out_en_o   = pwr_en_i && !ot_q && (phase != PH_OFF);
  assign ovl_flag_o = pwr_en_i && !ot_q &&
                      (static_mode_i ? clamp_flag_q : (phase != PH_IDLE));
  assign ot_flag_o  = ot_q;

  a_r2_disable: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !pwr_en_i |-> (!out_en_o && !ovl_flag_o));

  a_r9_hot_output_off: assert property (@(posedge clk) disable iff (!rst_n_sync)
    temp_hot_i |=> (ot_flag_o && !out_en_o));

  a_r7_clamp_stays_on: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (static_mode_i && $past(static_mode_i) && pwr_en_i && !ot_flag_o) |-> out_en_o);

  a_r11_no_ovl_when_hot: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ot_flag_o |-> !ovl_flag_o);

endmodule

// File: tb/tb_load_fault_sequencer.sv
module tb_load_fault_sequencer;

  localparam int unsigned OFF = 40;
  localparam int unsigned ON  = OFF / 10;

  logic clk;
  logic rst_n;
  logic pwr_en, static_mode, overload, temp_hot, temp_cool;
  logic out_en, ovl_flag, ot_flag;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  load_fault_sequencer #(.OFF_CYCLES(OFF)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwr_en_i      (pwr_en),
    .static_mode_i (static_mode),
    .overload_i    (overload),
    .temp_hot_i    (temp_hot),
    .temp_cool_i   (temp_cool),
    .out_en_o      (out_en),
    .ovl_flag_o    (ovl_flag),
    .ot_flag_o     (ot_flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic chk(input string tag, input string what, input logic got, input logic exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s at %0t: got %b expected %b", tag, what, $time, got, exp);
    end
  endtask

  task automatic chk3(input string tag, input logic e_en, input logic e_ovl, input logic e_ot);
    chk(tag, "out_en", out_en, e_en);
    chk(tag, "ovl_flag", ovl_flag, e_ovl);
    chk(tag, "ot_flag", ot_flag, e_ot);
  endtask

  task automatic run_n(input int n, input string tag, input logic e_en, input logic e_ovl, input logic e_ot);
    for (int i = 0; i < n; i++) begin
      tick();
      chk3(tag, e_en, e_ovl, e_ot);
    end
  endtask

  // Overload already low: remaining trial window, then idle.
  task automatic finish_clean();
    run_n(ON, "R4", 1'b1, 1'b1, 1'b0);
    run_n(3, "R6", 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pwr_en = 1'b1; static_mode = 1'b0;
    overload = 1'b0; temp_hot = 1'b0; temp_cool = 1'b0;
    #45;
    chk3("R1", 1'b1, 1'b0, 1'b0);
    rst_n = 1'b1;
    run_n(4, "R1", 1'b1, 1'b0, 1'b0);

    // Basic hiccup, overload held through the whole off period.
    overload = 1'b1;
    run_n(OFF, "R3", 1'b0, 1'b1, 1'b0);
    overload = 1'b0;
    finish_clean();

    // Overload during the first trial edge -> new full off period.
    overload = 1'b1;
    run_n(OFF, "R3", 1'b0, 1'b1, 1'b0);
    run_n(1, "R4", 1'b1, 1'b1, 1'b0);
    run_n(1, "R5", 1'b0, 1'b1, 1'b0);
    overload = 1'b0;
    run_n(OFF - 1, "R5", 1'b0, 1'b1, 1'b0);
    finish_clean();

    // Overload only at the last trial edge.
    overload = 1'b1;
    run_n(OFF, "R3", 1'b0, 1'b1, 1'b0);
    overload = 1'b0;
    run_n(ON, "R4", 1'b1, 1'b1, 1'b0);
    overload = 1'b1;
    run_n(1, "R5", 1'b0, 1'b1, 1'b0);
    overload = 1'b0;
    run_n(OFF - 1, "R5", 1'b0, 1'b1, 1'b0);
    finish_clean();

    // Overload pulse in the off period is ignored.
    overload = 1'b1;
    run_n(1, "R3", 1'b0, 1'b1, 1'b0);
    overload = 1'b0;
    run_n(5, "R3", 1'b0, 1'b1, 1'b0);
    overload = 1'b1;
    run_n(3, "R3", 1'b0, 1'b1, 1'b0);
    overload = 1'b0;
    run_n(OFF - 9, "R3", 1'b0, 1'b1, 1'b0);
    finish_clean();

    // Clamp mode.
    static_mode = 1'b1;
    overload = 1'b1;
    run_n(50, "R7", 1'b1, 1'b1, 1'b0);
    overload = 1'b0;
    run_n(2, "R7", 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 12; k++) begin
      logic v;
      v = ((k * 5) % 3) == 1;
      overload = v;
      tick();
      chk3("R7", 1'b1, v, 1'b0);
    end
    overload = 1'b0;
    run_n(2, "R7", 1'b1, 1'b0, 1'b0);

    // Clamp to pulsed with overload present.
    overload = 1'b1;
    run_n(1, "R7", 1'b1, 1'b1, 1'b0);
    static_mode = 1'b0;
    run_n(OFF, "R8", 1'b0, 1'b1, 1'b0);
    overload = 1'b0;
    finish_clean();

    // Enable low mid-sequence.
    overload = 1'b1;
    run_n(5, "R3", 1'b0, 1'b1, 1'b0);
    pwr_en = 1'b0;
    #1;
    chk3("R2", 1'b0, 1'b0, 1'b0);
    run_n(4, "R2", 1'b0, 1'b0, 1'b0);
    overload = 1'b0;
    run_n(1, "R2", 1'b0, 1'b0, 1'b0);
    pwr_en = 1'b1;
    run_n(3, "R2", 1'b1, 1'b0, 1'b0);

    // Thermal hysteresis.
    temp_hot = 1'b1;
    run_n(2, "R9", 1'b0, 1'b0, 1'b1);
    temp_hot = 1'b0;
    run_n(6, "R10", 1'b0, 1'b0, 1'b1);
    temp_hot = 1'b1; temp_cool = 1'b1;
    run_n(2, "R9", 1'b0, 1'b0, 1'b1);
    temp_hot = 1'b0;
    run_n(1, "R10", 1'b1, 1'b0, 1'b0);
    temp_cool = 1'b0;
    run_n(2, "R10", 1'b1, 1'b0, 1'b0);

    // Thermal fault during hiccup, overload persists after cooling.
    overload = 1'b1;
    run_n(3, "R3", 1'b0, 1'b1, 1'b0);
    temp_hot = 1'b1;
    run_n(4, "R11", 1'b0, 1'b0, 1'b1);
    temp_hot = 1'b0; temp_cool = 1'b1;
    run_n(OFF, "R11", 1'b0, 1'b1, 1'b0);
    temp_cool = 1'b0;
    overload = 1'b0;
    finish_clean();

    // Thermal fault during hiccup, overload gone after cooling.
    overload = 1'b1;
    run_n(7, "R3", 1'b0, 1'b1, 1'b0);
    temp_hot = 1'b1;
    run_n(2, "R11", 1'b0, 1'b0, 1'b1);
    overload = 1'b0;
    temp_hot = 1'b0; temp_cool = 1'b1;
    run_n(3, "R11", 1'b1, 1'b0, 1'b0);
    temp_cool = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule